// File: doc/BRIEF.md
# CAN Operating-Mode Sequencer

This block decides which operating mode a CAN protocol controller is in: initialization, normal traffic, sleep, or bus-off recovery. Software drives it with four control bits from a register interface. Two of them are requests: initialization and sleep. The other two enable automatic behaviour: wake-up on bus traffic, and hardware bus-off recovery. The bit-timing logic supplies a one-cycle sample strobe together with the sampled receive-line value. The protocol engine supplies three indications: a frame is in progress, the error logic has declared bus-off, and a start of frame has been detected.

Mode changes are never abrupt. Initialization and sleep are entered only once the frame in progress has finished. Leaving initialization or sleep requires 11 consecutive recessive sampled bits before the controller reports itself ready for traffic. Automatic bus-off recovery requires 128 such 11-bit runs. The block reports its mode through registered acknowledge and ready outputs. On an automatic wake-up it emits a one-cycle pulse that the register interface uses to clear the sleep request.

After reset the block sits in sleep with its sleep acknowledge raised. This matches a control register whose reset value has only the sleep request set.

Top module: `can_mode_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `sleep_ack` is 1 and `init_ack`, `ready` and `sleep_clr` are 0.
- R2: With `init_req` high, initialization is entered (`init_ack` rises) only on an edge where `bus_busy` is low; while `bus_busy` stays high the current mode is held.
- R3: When `init_req` and `sleep_req` are both high and the bus is idle, initialization is entered rather than sleep, from normal mode and from sleep mode.
- R4: After initialization or sleep is left, `ready` rises on the clock edge that samples the 11th consecutive recessive bit (`bit_stb`=1, `rx_bit`=1). A dominant sample (`bit_stb`=1, `rx_bit`=0) restarts the run. A strobe that lands on the same edge as the mode change does not count.
- R5: With `sleep_req` high and `init_req` low, sleep is entered (`sleep_ack` rises) only on an edge where `bus_busy` is low.
- R6: With `auto_wake_en` low, `sof_det` has no effect in sleep; sleep is left (`sleep_ack` falls, all outputs 0) on the edge where `sleep_req` is sampled low.
- R7: With `auto_wake_en` high, `sof_det` in sleep leaves sleep. `sleep_clr` is high for exactly the following cycle, and `sleep_req` still being high in that cycle does not re-enter sleep.
- R8: `bus_off` sampled high in normal mode or while resynchronizing moves the block to bus-off: `ready`, `init_ack` and `sleep_ack` are all 0.
- R9: With `auto_busoff_en` high, bus-off is left (`ready` rises) on the edge that completes exactly the 128th run of 11 consecutive recessive samples, and not one sample earlier.
- R10: In bus-off, a dominant sample restarts only the current 11-bit run; runs already completed still count toward the 128.
- R11: With `auto_busoff_en` low, recessive runs never end bus-off; setting `init_req` while the bus is idle moves it to initialization.
- R12: `rx_bit` is ignored on cycles where `bit_stb` is low; such cycles neither advance nor restart a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_req | input | 1 | Software request for initialization mode |
| sleep_req | input | 1 | Software request for sleep mode |
| auto_wake_en | input | 1 | Leave sleep by hardware on a detected start of frame |
| auto_busoff_en | input | 1 | Leave bus-off by hardware after 128 recessive runs |
| bit_stb | input | 1 | One-cycle strobe marking a bit sample point |
| rx_bit | input | 1 | Sampled receive line, 1 = recessive |
| bus_busy | input | 1 | A frame is being sent or received |
| bus_off | input | 1 | Error logic has declared bus-off |
| sof_det | input | 1 | Start of frame seen on the receive line |
| init_ack | output | 1 | Initialization mode is active |
| sleep_ack | output | 1 | Sleep mode is active |
| ready | output | 1 | Synchronized and ready for traffic |
| sleep_clr | output | 1 | One-cycle pulse that clears the sleep request bit |

## Verification
The assertions take the protocol engine's indications at face value. `bus_busy` is low between frames. A strobe lasts a single cycle. `bus_off` is a level the error logic drops once the block has entered bus-off. The register interface clears `sleep_req` on the edge after `sleep_clr`. The stimulus keeps to all of this. Every input is changed on the falling edge. `bus_off` is held for one cycle only. `sleep_req` is dropped in the cycle after the clear pulse, as the register would do. Recessive runs are built only from strobed samples, with dominant and unstrobed samples placed inside runs.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

  typedef enum logic [2:0] {
    MD_INIT   = 3'd0,
    MD_SYNC   = 3'd1,
    MD_RUN    = 3'd2,
    MD_SLEEP  = 3'd3,
    MD_BUSOFF = 3'd4
  } can_mode_e;

endpackage

// File: rtl/can_recessive_run.sv
// Counts consecutive recessive samples; pulses run_done on the sample that
// completes a run of RUN_LEN, then starts over.
module can_recessive_run #(
  parameter int RUN_LEN = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  input  logic stb,
  input  logic rx,
  output logic run_done
);

  localparam int W = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1;

  logic [W-1:0] cnt;
  logic         at_end;

  assign at_end   = (cnt == W'(RUN_LEN - 1));
  assign run_done = en && stb && rx && at_end;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (en && stb) begin
      if (!rx || at_end) cnt <= '0;
      else               cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/can_run_tally.sv
// Counts completed recessive runs during bus-off; flags the last one.
module can_run_tally #(
  parameter int RUN_SETS = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last
);

  localparam int W = (RUN_SETS > 2) ? $clog2(RUN_SETS) : 1;

  logic [W-1:0] cnt;

  assign last = (cnt == W'(RUN_SETS - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/can_mode_fsm.sv
// Mode state machine with outputs registered from the next state.
module can_mode_fsm
  import can_mode_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic init_req,
  input  logic sleep_req,
  input  logic auto_wake_en,
  input  logic auto_busoff_en,
  input  logic bus_busy,
  input  logic bus_off,
  input  logic sof_det,
  input  logic run_done,
  input  logic tally_last,
  output logic cnt_en,
  output logic cnt_clr,
  output logic tally_inc,
  output logic init_ack,
  output logic sleep_ack,
  output logic ready,
  output logic sleep_clr
);

  can_mode_e state, nxt;
  logic      wake;
  logic      idle;
  logic      go_init;
  logic      go_sleep;

  assign idle     = !bus_busy;
  assign go_init  = init_req && idle;
  // the sleep bit is still set in the cycle of the clear pulse; mask it
  assign go_sleep = sleep_req && idle && !sleep_clr;

  always_comb begin
    nxt  = state;
    wake = 1'b0;
    unique case (state)
      MD_INIT: begin
        if (!init_req) nxt = go_sleep ? MD_SLEEP : MD_SYNC;
      end
      MD_SYNC: begin
        if (bus_off)       nxt = MD_BUSOFF;
        else if (go_init)  nxt = MD_INIT;
        else if (go_sleep) nxt = MD_SLEEP;
        else if (run_done) nxt = MD_RUN;
      end
      MD_RUN: begin
        if (bus_off)       nxt = MD_BUSOFF;
        else if (go_init)  nxt = MD_INIT;
        else if (go_sleep) nxt = MD_SLEEP;
      end
      MD_SLEEP: begin
        if (go_init) begin
          nxt = MD_INIT;
        end else if (!sleep_req) begin
          nxt = MD_SYNC;
        end else if (auto_wake_en && sof_det) begin
          nxt  = MD_SYNC;
          wake = 1'b1;
        end
      end
      MD_BUSOFF: begin
        if (go_init)
          nxt = MD_INIT;
        else if (auto_busoff_en && run_done && tally_last)
          nxt = MD_RUN;
      end
      default: nxt = MD_INIT;
    endcase
  end

  assign cnt_en    = (state == MD_SYNC) || (state == MD_BUSOFF);
  assign cnt_clr   = (nxt != state);
  assign tally_inc = (state == MD_BUSOFF) && run_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= MD_SLEEP;
      init_ack  <= 1'b0;
      sleep_ack <= 1'b1;
      ready     <= 1'b0;
      sleep_clr <= 1'b0;
    end else begin
      state     <= nxt;
      init_ack  <= (nxt == MD_INIT);
      sleep_ack <= (nxt == MD_SLEEP);
      ready     <= (nxt == MD_RUN);
      sleep_clr <= wake;
    end
  end

endmodule

// File: rtl/can_mode_seq.sv
// Top level: operating-mode sequencer for a CAN protocol controller.
module can_mode_seq #(
  parameter int RUN_LEN  = 11,
  parameter int RUN_SETS = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic init_req,
  input  logic sleep_req,
  input  logic auto_wake_en,
  input  logic auto_busoff_en,
  input  logic bit_stb,
  input  logic rx_bit,
  input  logic bus_busy,
  input  logic bus_off,
  input  logic sof_det,
  output logic init_ack,
  output logic sleep_ack,
  output logic ready,
  output logic sleep_clr
);

  logic cnt_en;
  logic cnt_clr;
  logic tally_inc;
  logic run_done;
  logic tally_last;

  can_recessive_run #(.RUN_LEN(RUN_LEN)) u_run (
    .clk      (clk),
    .rst      (rst),
    .clr      (cnt_clr),
    .en       (cnt_en),
    .stb      (bit_stb),
    .rx       (rx_bit),
    .run_done (run_done)
  );

  can_run_tally #(.RUN_SETS(RUN_SETS)) u_tally (
    .clk  (clk),
    .rst  (rst),
    .clr  (cnt_clr),
    .inc  (tally_inc),
    .last (tally_last)
  );

  can_mode_fsm u_fsm (
    .clk            (clk),
    .rst            (rst),
    .init_req       (init_req),
    .sleep_req      (sleep_req),
    .auto_wake_en   (auto_wake_en),
    .auto_busoff_en (auto_busoff_en),
    .bus_busy       (bus_busy),
    .bus_off        (bus_off),
    .sof_det        (sof_det),
    .run_done       (run_done),
    .tally_last     (tally_last),
    .cnt_en         (cnt_en),
    .cnt_clr        (cnt_clr),
    .tally_inc      (tally_inc),
    .init_ack       (init_ack),
    .sleep_ack      (sleep_ack),
    .ready          (ready),
    .sleep_clr      (sleep_clr)
  );

endmodule

// File: rtl/can_mode_seq_chk.sv
module can_mode_seq_chk (
  input logic clk,
  input logic rst,
  input logic init_req,
  input logic sleep_req,
  input logic auto_wake_en,
  input logic bit_stb,
  input logic rx_bit,
  input logic bus_busy,
  input logic bus_off,
  input logic sof_det,
  input logic init_ack,
  input logic sleep_ack,
  input logic ready,
  input logic sleep_clr
);

  AST_ONE_MODE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({init_ack, sleep_ack, ready})); // R1

  AST_INIT_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(init_ack) |-> $past(init_req && !bus_busy)); // R2

  AST_SLEEP_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(sleep_ack) |-> $past(sleep_req && !init_req && !bus_busy)); // R5

  AST_READY_ON_RECESSIVE: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(bit_stb && rx_bit)); // R4

  AST_WAKE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    ($fell(sleep_ack) && !init_ack) |-> $past(!sleep_req || (auto_wake_en && sof_det))); // R6

  AST_CLR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    sleep_clr |-> $past(auto_wake_en && sof_det && sleep_ack)); // R7

  AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    sleep_clr |=> !sleep_clr); // R7

  AST_BUSOFF_DROP: assert property (@(posedge clk) disable iff (rst)
    ($fell(ready) && !init_ack && !sleep_ack) |-> $past(bus_off)); // R8

endmodule

bind can_mode_seq can_mode_seq_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .init_req     (init_req),
  .sleep_req    (sleep_req),
  .auto_wake_en (auto_wake_en),
  .bit_stb      (bit_stb),
  .rx_bit       (rx_bit),
  .bus_busy     (bus_busy),
  .bus_off      (bus_off),
  .sof_det      (sof_det),
  .init_ack     (init_ack),
  .sleep_ack    (sleep_ack),
  .ready        (ready),
  .sleep_clr    (sleep_clr)
);

// File: tb/can_mode_seq_bench.sv
module can_mode_seq_bench;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic init_req = 1'b0, sleep_req = 1'b1, auto_wake_en = 1'b0, auto_busoff_en = 1'b0;
  logic bit_stb = 1'b0, rx_bit = 1'b1, bus_busy = 1'b0, bus_off = 1'b0, sof_det = 1'b0;
  logic init_ack, sleep_ack, ready, sleep_clr;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  can_mode_seq u_can_mode_seq (
    .clk(clk), .rst(rst), .init_req(init_req), .sleep_req(sleep_req),
    .auto_wake_en(auto_wake_en), .auto_busoff_en(auto_busoff_en),
    .bit_stb(bit_stb), .rx_bit(rx_bit), .bus_busy(bus_busy), .bus_off(bus_off),
    .sof_det(sof_det), .init_ack(init_ack), .sleep_ack(sleep_ack),
    .ready(ready), .sleep_clr(sleep_clr)
  );

  // row: {req[24:21], reps[20:13], stim[12:4], exp[3:0]}
  // stim: init, sleep, awake, abusoff, stb, rx, busy, busoff, sof
  // exp : init_ack, sleep_ack, ready, sleep_clr
  localparam int NV = 33;
  localparam logic [24:0] VEC [NV] = '{
    {4'd1,  8'd2,  9'b010000000, 4'b0100}, // R1 stays asleep
    {4'd3,  8'd2,  9'b110000000, 4'b1000}, // R3 init beats sleep
    {4'd4,  8'd1,  9'b000000000, 4'b0000}, // R4 leave init
    {4'd4,  8'd10, 9'b000011000, 4'b0000}, // R4
    {4'd4,  8'd1,  9'b000010000, 4'b0000}, // R4 dominant restarts
    {4'd4,  8'd5,  9'b000011000, 4'b0000}, // R4
    {4'd12, 8'd5,  9'b000001000, 4'b0000}, // R12 no strobe
    {4'd4,  8'd5,  9'b000011000, 4'b0000}, // R4
    {4'd4,  8'd1,  9'b000011000, 4'b0010}, // R4 11th recessive
    {4'd2,  8'd3,  9'b100000100, 4'b0010}, // R2 busy holds
    {4'd2,  8'd1,  9'b100000000, 4'b1000}, // R2 idle enters
    {4'd4,  8'd1,  9'b000011000, 4'b0000}, // R4 edge strobe not counted
    {4'd4,  8'd10, 9'b000011000, 4'b0000}, // R4
    {4'd4,  8'd1,  9'b000011000, 4'b0010}, // R4
    {4'd5,  8'd3,  9'b010000100, 4'b0010}, // R5 busy holds
    {4'd5,  8'd1,  9'b010000000, 4'b0100}, // R5 idle enters
    {4'd6,  8'd2,  9'b010000001, 4'b0100}, // R6 sof ignored
    {4'd6,  8'd1,  9'b000000000, 4'b0000}, // R6 software wake
    {4'd4,  8'd10, 9'b000011000, 4'b0000}, // R4
    {4'd4,  8'd1,  9'b000011000, 4'b0010}, // R4
    {4'd5,  8'd1,  9'b010000000, 4'b0100}, // R5
    {4'd7,  8'd1,  9'b011000001, 4'b0001}, // R7 auto wake
    {4'd7,  8'd1,  9'b011000000, 4'b0000}, // R7 no re-entry, single pulse
    {4'd7,  8'd2,  9'b001000000, 4'b0000}, // R7
    {4'd4,  8'd10, 9'b001011000, 4'b0000}, // R4
    {4'd4,  8'd1,  9'b001011000, 4'b0010}, // R4
    {4'd3,  8'd1,  9'b110000000, 4'b1000}, // R3 from normal
    {4'd3,  8'd1,  9'b010000000, 4'b0100}, // R3 then sleep
    {4'd6,  8'd1,  9'b000000000, 4'b0000}, // R6
    {4'd4,  8'd10, 9'b000011000, 4'b0000}, // R4
    {4'd4,  8'd1,  9'b000011000, 4'b0010}, // R4
    {4'd8,  8'd1,  9'b000000010, 4'b0000}, // R8 bus-off entry
    {4'd11, 8'd20, 9'b000011000, 4'b0000}  // R11 manual stays
  };

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  task automatic drive(input logic [8:0] s);
    {init_req, sleep_req, auto_wake_en, auto_busoff_en,
     bit_stb, rx_bit, bus_busy, bus_off, sof_det} = s;
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {init_ack, sleep_ack, ready, sleep_clr};
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {init_ack,sleep_ack,ready,sleep_clr} got %b expected %b",
               req, act, exp);
    end
  endtask

  task automatic feed(input int n, input logic [8:0] s);
    drive(s);
    for (int k = 0; k < n; k++) cyc();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    drive(9'b010000000);
    cyc();
    check("R1", 4'b0100);
    cyc();
    rst = 1'b0;
    check("R1", 4'b0100);
  endtask

  task automatic go_normal(input logic abo);
    feed(1, {3'b000, abo, 5'b00000});
    feed(10, {3'b000, abo, 5'b11000});
    feed(1, {3'b000, abo, 5'b11000});
    check("R4", 4'b0010);
  endtask

  initial begin
    @(negedge clk);
    do_reset();

    for (int i = 0; i < NV; i++) begin
      for (int k = 0; k < int'(VEC[i][20:13]); k++) begin
        drive(VEC[i][12:4]);
        cyc();
        check($sformatf("R%0d", VEC[i][24:21]), VEC[i][3:0]);
      end
    end

    // mid-run reset, R1
    do_reset();

    // automatic bus-off recovery: R9, R10
    go_normal(1'b1);
    feed(1, 9'b000100010);
    check("R8", 4'b0000);
    feed(33, 9'b000111000);        // three full runs
    feed(4, 9'b000111000);
    feed(1, 9'b000110000);         // dominant: only the partial run is lost
    feed(125 * 11 - 1, 9'b000111000);
    check("R10", 4'b0000);
    feed(1, 9'b000111000);
    check("R9", 4'b0010);

    // manual bus-off: R11
    feed(1, 9'b000000010);
    check("R8", 4'b0000);
    feed(1500, 9'b000011000);
    check("R11", 4'b0000);
    feed(1, 9'b100000000);
    check("R11", 4'b1000);
    go_normal(1'b0);

    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run still going, expected completion");
    finish_run();
  end

endmodule